// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is an SPI slave that takes fixed 16-bit command frames from a host controller and turns each valid frame into a write to one of two internal registers. The frame is split into a 4-bit opcode in its upper bits and a 12-bit payload in its lower bits. One opcode loads the payload into a 12-bit operating-mode register. The value zero in that register means the front end is switched off. A second opcode copies bit 0 of the payload into a single trace-enable flag. Every other opcode is dropped without effect.

The serial pins run at a rate well below the system clock. They pass through synchronisers, and the block detects clock edges in the system clock domain. A frame counts only when the select pulse that encloses it holds exactly sixteen rising serial-clock edges. Each accepted write raises a one-cycle strobe, so the logic downstream knows when to act on the new setting.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset `mode_reg` is 0, `trace_en` is 0 and `upd_stb` is 0.
- R2: Serial data is sampled on rising `sck` edges while `cs_n` is low (clock idles low, SPI mode 0), most significant bit first; of the 16-bit word, bits 15..12 are the opcode and bits 11..0 the payload.
- R3: A frame with opcode 4'h1 loads the 12-bit payload into `mode_reg`.
- R4: A frame with opcode 4'h2 sets `trace_en` to payload bit 0; payload bits 11..1 have no effect on any output.
- R5: A frame with any other opcode changes no output and raises no strobe.
- R6: A select pulse with fewer than 16 rising `sck` edges is discarded: no output changes.
- R7: A select pulse with more than 16 rising `sck` edges is discarded: no output changes.
- R8: `upd_stb` is high for exactly one cycle for each accepted opcode-1 or opcode-2 frame, in the same cycle the register shows the new value, and at no other time.
- R9: Writing payload 0 with opcode 4'h1 returns `mode_reg` to 0, the front-end-off mode, from any earlier value.
- R10: The register update and strobe appear no more than 5 system clock cycles after `cs_n` rises.
- R11: `sck` edges while `cs_n` is high are ignored and do not corrupt the next frame.
- R12: `miso` is held low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Frame select from the host, active low |
| miso | output | 1 | Serial data to the host, held low |
| mode_reg | output | 12 | Operating-mode register, 0 means off |
| trace_en | output | 1 | Trace-enable flag |
| upd_stb | output | 1 | One-cycle pulse when a register is written |

## Verification
A wrong bit count or a shifted bit order shows at the ports as a frame that is rejected, or as a payload written in the wrong bit positions. Both are visible within five cycles of the select edge. A stuck opcode decode shows as a strobe on an ignored opcode, or as a missing strobe. A corrupted mode or trace register differs from the bench's reference state on the very next compared clock. Frames that are too short or too long, and clock activity while select is high, are followed by a correct frame, so any count left over from them shows up as a rejected later write.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_MODE  = 2'd1,
      OP_TRACE = 2'd2
   } op_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int unsigned             WIDTH   = 3,
   parameter int unsigned             STAGES  = 2,
   parameter logic [WIDTH-1:0]        RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cmd_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
   parameter int unsigned FRAME_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sck_s,
   input  logic                  mosi_s,
   input  logic                  cs_s,
   output logic                  frame_vld,
   output logic [FRAME_BITS-1:0] frame_word
);
   localparam int unsigned CNT_MAX = FRAME_BITS + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("spi_cmd_shift: FRAME_BITS must be at least 2");
   end

   logic                  sck_d, cs_d;
   logic [FRAME_BITS-1:0] shreg;
   logic [CNT_W-1:0]      bit_cnt;
   logic                  sck_rise, cs_rise;

   assign sck_rise = sck_s & ~sck_d & ~cs_s;
   assign cs_rise  = cs_s & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d      <= 1'b0;
         cs_d       <= 1'b1;
         shreg      <= '0;
         bit_cnt    <= '0;
         frame_vld  <= 1'b0;
         frame_word <= '0;
      end else begin
         sck_d     <= sck_s;
         cs_d      <= cs_s;
         frame_vld <= 1'b0;
         if (cs_s)
            bit_cnt <= '0;
         else if (sck_rise && bit_cnt != CNT_W'(CNT_MAX))
            bit_cnt <= bit_cnt + 1'b1;
         if (sck_rise)
            shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
         if (cs_rise && bit_cnt == CNT_W'(FRAME_BITS)) begin
            frame_vld  <= 1'b1;
            frame_word <= shreg;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(CNT_MAX)); // R7
   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> bit_cnt == '0); // R11
   AST_VLD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld |-> $past(bit_cnt) == CNT_W'(FRAME_BITS)); // R6
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
   import spi_cmd_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 16,
   parameter int unsigned CMD_BITS   = 4,
   parameter int unsigned MODE_OP    = 1,
   parameter int unsigned TRACE_OP   = 2,
   parameter int unsigned TRACE_BIT  = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           frame_vld,
   input  logic [FRAME_BITS-1:0]          frame_word,
   output logic [FRAME_BITS-CMD_BITS-1:0] mode_q,
   output logic                           trace_q,
   output logic                           upd_stb
);
   localparam int unsigned DATA_BITS = FRAME_BITS - CMD_BITS;

   if (CMD_BITS == 0 || CMD_BITS >= FRAME_BITS) begin : g_bad_split
      $error("spi_cmd_decode: CMD_BITS must lie inside the frame");
   end
   if (TRACE_BIT >= DATA_BITS) begin : g_bad_tbit
      $error("spi_cmd_decode: TRACE_BIT outside payload");
   end
   if (MODE_OP == TRACE_OP) begin : g_bad_ops
      $error("spi_cmd_decode: opcodes must differ");
   end

   logic [CMD_BITS-1:0]  opcode;
   logic [DATA_BITS-1:0] payload;
   op_e                  op;

   assign opcode  = frame_word[FRAME_BITS-1 -: CMD_BITS];
   assign payload = frame_word[DATA_BITS-1:0];

   always_comb begin
      op = OP_NONE;
      if (frame_vld) begin
         if (opcode == CMD_BITS'(MODE_OP))       op = OP_MODE;
         else if (opcode == CMD_BITS'(TRACE_OP)) op = OP_TRACE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         trace_q <= 1'b0;
         upd_stb <= 1'b0;
      end else begin
         upd_stb <= 1'b0;
         unique case (op)
            OP_MODE: begin
               mode_q  <= payload;
               upd_stb <= 1'b1;
            end
            OP_TRACE: begin
               trace_q <= payload[TRACE_BIT];
               upd_stb <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> !upd_stb); // R8
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |-> $stable(mode_q)); // R5
   AST_TRACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |-> $stable(trace_q)); // R4
   AST_STB_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> $past(frame_vld)); // R8
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
   parameter int unsigned FRAME_BITS  = 16,
   parameter int unsigned CMD_BITS    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MODE_OP     = 1,
   parameter int unsigned TRACE_OP    = 2,
   parameter int unsigned TRACE_BIT   = 0,
   localparam int unsigned DATA_BITS  = FRAME_BITS - CMD_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sck,
   input  logic                 mosi,
   input  logic                 cs_n,
   output logic                 miso,
   output logic [DATA_BITS-1:0] mode_reg,
   output logic                 trace_en,
   output logic                 upd_stb
);
   logic [2:0]            pins_s;
   logic                  frame_vld;
   logic [FRAME_BITS-1:0] frame_word;

   // bit 2: select (idles high), bit 1: clock, bit 0: data
   spi_cmd_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({cs_n, sck, mosi}),
      .q_out (pins_s)
   );

   spi_cmd_shift #(
      .FRAME_BITS (FRAME_BITS)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_s      (pins_s[1]),
      .mosi_s     (pins_s[0]),
      .cs_s       (pins_s[2]),
      .frame_vld  (frame_vld),
      .frame_word (frame_word)
   );

   spi_cmd_decode #(
      .FRAME_BITS (FRAME_BITS),
      .CMD_BITS   (CMD_BITS),
      .MODE_OP    (MODE_OP),
      .TRACE_OP   (TRACE_OP),
      .TRACE_BIT  (TRACE_BIT)
   ) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_vld  (frame_vld),
      .frame_word (frame_word),
      .mode_q     (mode_reg),
      .trace_q    (trace_en),
      .upd_stb    (upd_stb)
   );

   assign miso = 1'b0;
endmodule

// File: tb/spi_cmd_rx_test.sv
module spi_cmd_rx_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        mosi = 1'b0;
   logic        cs_n = 1'b1;
   logic        miso;
   logic [11:0] mode_reg;
   logic        trace_en;
   logic        upd_stb;

   int n_checks = 0;
   int n_fail = 0;

   // reference state
   logic [11:0] exp_mode = '0;
   logic        exp_trace = 1'b0;
   bit          pend = 1'b0;
   logic [11:0] pend_mode;
   logic        pend_trace;
   bit          monitor_on = 1'b0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_cmd_rx uut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
      .miso(miso), .mode_reg(mode_reg), .trace_en(trace_en), .upd_stb(upd_stb)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // per-clock comparison with the reference model
   always @(negedge clk) begin
      #1;
      if (monitor_on) begin
         if (upd_stb) begin
            check(pend, "R8", "strobe with no accepted frame", 1, 0);
            if (pend) begin
               exp_mode  = pend_mode;
               exp_trace = pend_trace;
               pend      = 1'b0;
            end
         end
         check(mode_reg == exp_mode, "R3", "mode_reg", mode_reg, exp_mode);
         check(trace_en == exp_trace, "R4", "trace_en", trace_en, exp_trace);
         check(miso == 1'b0, "R12", "miso", miso, 0);
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // send nbits of word, MSB first; the last 16 bits are the frame
   task automatic send_bits(input logic [31:0] word, input int nbits);
      cs_n = 1'b0;
      wait_clk(4);
      for (int i = nbits - 1; i >= 0; i--) begin
         mosi = word[i];
         wait_clk(3);
         sck = 1'b1;
         wait_clk(3);
         sck = 1'b0;
      end
      wait_clk(3);
   endtask

   task automatic end_frame(input bit accept, input logic [11:0] nm, input logic nt,
                            input string req);
      if (accept) begin
         pend_mode  = nm;
         pend_trace = nt;
         pend       = 1'b1;
      end
      cs_n = 1'b1;
      wait_clk(5);
      #2;
      check(!pend, req, "update not seen within 5 cycles (R10)", 0, 1);
      pend = 1'b0;
      wait_clk(4);
   endtask

   task automatic frame16(input logic [15:0] w, input string req);
      logic [3:0]  op;
      logic [11:0] d;
      op = w[15:12];
      d  = w[11:0];
      send_bits({16'h0, w}, 16);
      if (op == 4'h1)      end_frame(1'b1, d, exp_trace, req);
      else if (op == 4'h2) end_frame(1'b1, exp_mode, d[0], req);
      else                 end_frame(1'b0, exp_mode, exp_trace, req);
   endtask

   initial begin
      wait_clk(3);
      #2;
      check(mode_reg == 12'h0, "R1", "reset mode_reg", mode_reg, 0);
      check(trace_en == 1'b0, "R1", "reset trace_en", trace_en, 0);
      check(upd_stb == 1'b0, "R1", "reset upd_stb", upd_stb, 0);
      rst_n = 1'b1;
      monitor_on = 1'b1;
      wait_clk(4);

      frame16(16'h1ABC, "R2");      // R2 bit order and split, R3 mode load
      frame16(16'h1543, "R3");
      frame16(16'h2001, "R4");      // trace on
      frame16(16'h2FFE, "R4");      // bit 0 clear: trace off, other bits ignored
      frame16(16'h2003, "R4");
      frame16(16'h3555, "R5");      // ignored opcodes
      frame16(16'h0FFF, "R5");
      frame16(16'hF123, "R5");
      // R6: 15-bit frame carrying a mode opcode
      send_bits({17'h0, 15'h1777}, 15);
      end_frame(1'b0, exp_mode, exp_trace, "R6");
      // R7: 17-bit frame whose last 16 bits would be a valid write
      send_bits({15'h0, 17'h11234}, 17);
      end_frame(1'b0, exp_mode, exp_trace, "R7");
      // R11: clock activity while deselected, then a clean frame
      for (int i = 0; i < 10; i++) begin
         mosi = i[0];
         wait_clk(3);
         sck = 1'b1;
         wait_clk(3);
         sck = 1'b0;
      end
      wait_clk(4);
      frame16(16'h1FFF, "R11");
      frame16(16'h1000, "R9");      // back to the off mode
      check(mode_reg == 12'h0, "R9", "mode off", mode_reg, 0);
      frame16(16'h2000, "R8");
      frame16(16'h1800, "R8");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule